// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block sequences the bring-up of a PCIe root-port link after its controller and PHY have been configured. When a start pulse arrives, it limits the advertised maximum speed to Gen1 and enables link training. It then waits for the PHY to report link-up. After the first link-up it may lift the speed limit to Gen2. It then issues one directed speed-change request, polls the request bit until the controller clears it, and waits for the link to come up a second time. On success it reports the negotiated generation, which it takes from the link status word.

Any failure sends the sequencer into PHY recovery. The failures are a link-up timeout in either wait, or a speed change that does not complete. During recovery the sequencer forces two receiver-override bits high for a fixed hold time, then releases them and raises fail.

The status words arrive as plain 32-bit inputs and the control fields leave as plain outputs. The register bus and the training logic sit outside the block. All waits share one down-counter.

Top module: `lnk_bringup`

## Requirements
- R1: After a synchronous reset, `speed_cap_o` is 1, and `train_en_o`, `spd_chg_req_o`, `rx_ovrd_o`, `done_o`, `fail_o` and `gen_o` are all zero.
- R2: When a start is accepted, `train_en_o` goes low and `speed_cap_o` is set to 1 (Gen1). Training is then enabled with `speed_cap_o` still 1, and `train_en_o` stays high after the run ends.
- R3: Link-up is bit 4 of `phy_dbg_i`, and no other bit of that word has any effect. If the first link-up does not arrive within `LINK_TMO` cycles, the run fails.
- R4: After the first link-up, `speed_cap_o` becomes 2 only when `max_gen_i` equals 2. For any other value it stays 1.
- R5: A run that reaches the first link-up emits exactly one single-cycle pulse on `spd_chg_req_o`. A run that fails before the first link-up emits none.
- R6: Bit 17 of `wsc_i` high means the speed change is still in progress. The block checks that bit once every `POLL_GAP` cycles, up to `POLL_LIMIT` times. If the bit is still high after the last check, the run fails. No other bit of `wsc_i` has any effect.
- R7: After the speed change completes, a second link-up wait of `LINK_TMO` cycles must succeed before `done_o` is raised. Otherwise the run fails.
- R8: On any failure, `rx_ovrd_o` equals 0x0028 (bits 5 and 3 set) for exactly `OVRD_HOLD` cycles. It then returns to zero and `fail_o` rises. Outside recovery, `rx_ovrd_o` is zero.
- R9: On success, `gen_o` holds bits 19:16 of `lcsr_i` as sampled when the second link-up is seen. On failure, `gen_o` is 0.
- R10: `done_o` and `fail_o` are never high together. Each holds its value until the next accepted start, which clears both.
- R11: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| max_gen_i | input | 4 | Configured maximum generation (2 allows Gen2) |
| phy_dbg_i | input | 32 | PHY debug word; bit 4 is link-up |
| wsc_i | input | 32 | Width/speed control readback; bit 17 is speed change busy |
| lcsr_i | input | 32 | Link control/status word; bits 19:16 are the current generation |
| speed_cap_o | output | 4 | Maximum-link-speed field to program |
| train_en_o | output | 1 | Link training enable |
| spd_chg_req_o | output | 1 | One-cycle request that sets the directed speed change bit |
| rx_ovrd_o | output | 16 | Receiver override bits driven during recovery |
| done_o | output | 1 | Run finished with the link up |
| fail_o | output | 1 | Run failed and recovery has completed |
| gen_o | output | 4 | Reported generation |

## Verification
The bench drives link-up arrival just inside and just outside the link timeout. A counter that is off by a few cycles, or one that never expires, would flip the outcome of those runs. It holds the speed change busy bit for slightly fewer, and then slightly more, than `POLL_LIMIT` × `POLL_GAP` cycles, which catches a poll count that is wrong or a busy bit that is read with the wrong sense. The unused bits of every status word carry random values on every cycle, so decoding a wrong bit position produces wrong outcomes. The bench also measures the length of the override pulse, checks the speed cap for `max_gen_i` values of 1, 2 and 3, and pulses start in the middle of a run to catch a sequencer that restarts.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENABLE,
    ST_WAIT1,
    ST_RAISE,
    ST_POLL,
    ST_WAIT2,
    ST_OVSET,
    ST_OVHOLD
  } lnk_state_e;

  localparam int LINK_UP_BIT  = 4;
  localparam int SPD_BUSY_BIT = 17;
  localparam int GEN_LSB      = 16;
  localparam int OVRD_W       = 16;
  localparam logic [OVRD_W-1:0] OVRD_MASK = 16'h0028;
  localparam logic [3:0] CAP_GEN1 = 4'd1;
  localparam logic [3:0] CAP_GEN2 = 4'd2;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lnk_timer.sv
module lnk_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load_i)
      cnt <= val_i;
    else if (dec_i && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/lnk_poll_ctr.sv
module lnk_poll_ctr #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PW-1:0] LAST_V = PW'(LIMIT - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt <= '0;
    else if (inc_i && cnt != LAST_V)
      cnt <= cnt + 1'b1;
  end

  assign last_o = (cnt == LAST_V);
endmodule

// File: rtl/lnk_fsm.sv
module lnk_fsm
  import lnk_pkg::*;
#(
  parameter int TW        = 8,
  parameter int LINK_TMO  = 100,
  parameter int POLL_GAP  = 8,
  parameter int OVRD_HOLD = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [3:0]    max_gen_i,
  input  logic          link_up_i,
  input  logic          spd_busy_i,
  input  logic [3:0]    gen_fld_i,
  input  logic          t_zero_i,
  input  logic          p_last_i,
  output logic          t_load_o,
  output logic [TW-1:0] t_val_o,
  output logic          t_dec_o,
  output logic          p_clr_o,
  output logic          p_inc_o,
  output logic [3:0]    cap_o,
  output logic          train_o,
  output logic          req_o,
  output logic          ovrd_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [3:0]    gen_o
);
  localparam logic [TW-1:0] TMO_V  = TW'(LINK_TMO - 1);
  localparam logic [TW-1:0] GAP_V  = TW'(POLL_GAP - 1);
  localparam logic [TW-1:0] HOLD_V = TW'(OVRD_HOLD - 1);

  lnk_state_e st, nxt;

  always_comb begin
    nxt      = st;
    t_load_o = 1'b0;
    t_val_o  = '0;
    t_dec_o  = 1'b0;
    p_clr_o  = 1'b0;
    p_inc_o  = 1'b0;
    case (st)
      ST_IDLE: if (start_i) nxt = ST_ENABLE;
      ST_ENABLE: begin
        nxt      = ST_WAIT1;
        t_load_o = 1'b1;
        t_val_o  = TMO_V;
      end
      ST_WAIT1: begin
        if (link_up_i)     nxt = ST_RAISE;
        else if (t_zero_i) nxt = ST_OVSET;
        else               t_dec_o = 1'b1;
      end
      ST_RAISE: begin
        nxt      = ST_POLL;
        t_load_o = 1'b1;
        t_val_o  = GAP_V;
        p_clr_o  = 1'b1;
      end
      ST_POLL: begin
        if (!t_zero_i) begin
          t_dec_o = 1'b1;
        end else if (!spd_busy_i) begin
          nxt      = ST_WAIT2;
          t_load_o = 1'b1;
          t_val_o  = TMO_V;
        end else if (p_last_i) begin
          nxt = ST_OVSET;
        end else begin
          p_inc_o  = 1'b1;
          t_load_o = 1'b1;
          t_val_o  = GAP_V;
        end
      end
      ST_WAIT2: begin
        if (link_up_i)     nxt = ST_IDLE;
        else if (t_zero_i) nxt = ST_OVSET;
        else               t_dec_o = 1'b1;
      end
      ST_OVSET: begin
        nxt      = ST_OVHOLD;
        t_load_o = 1'b1;
        t_val_o  = HOLD_V;
      end
      ST_OVHOLD: begin
        if (t_zero_i) nxt = ST_IDLE;
        else          t_dec_o = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cap_o   <= CAP_GEN1;
      train_o <= 1'b0;
      req_o   <= 1'b0;
      ovrd_o  <= 1'b0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      gen_o   <= '0;
    end else begin
      st    <= nxt;
      req_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          done_o  <= 1'b0;
          fail_o  <= 1'b0;
          gen_o   <= '0;
          cap_o   <= CAP_GEN1;
          train_o <= 1'b0;
        end
        ST_ENABLE: train_o <= 1'b1;
        ST_WAIT1: if (link_up_i)
          cap_o <= (max_gen_i == 4'd2) ? CAP_GEN2 : CAP_GEN1;
        ST_RAISE: req_o <= 1'b1;
        ST_WAIT2: if (link_up_i) begin
          done_o <= 1'b1;
          gen_o  <= gen_fld_i;
        end
        ST_OVSET: ovrd_o <= 1'b1;
        ST_OVHOLD: if (t_zero_i) begin
          ovrd_o <= 1'b0;
          fail_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lnk_bringup.sv
module lnk_bringup
  import lnk_pkg::*;
#(
  parameter int LINK_TMO   = 50000,
  parameter int POLL_GAP   = 20000,
  parameter int POLL_LIMIT = 200,
  parameter int OVRD_HOLD  = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [3:0]        max_gen_i,
  input  logic [31:0]       phy_dbg_i,
  input  logic [31:0]       wsc_i,
  input  logic [31:0]       lcsr_i,
  output logic [3:0]        speed_cap_o,
  output logic              train_en_o,
  output logic              spd_chg_req_o,
  output logic [OVRD_W-1:0] rx_ovrd_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [3:0]        gen_o
);
  localparam int MAXV = max3(LINK_TMO, POLL_GAP, OVRD_HOLD);
  localparam int TW   = $clog2(MAXV + 1);

  logic          t_load, t_dec, t_zero, p_clr, p_inc, p_last, ovrd;
  logic [TW-1:0] t_val;
  logic          unused_bits;

  assign unused_bits = ^{phy_dbg_i, wsc_i, lcsr_i};

  lnk_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(t_load), .val_i(t_val),
    .dec_i(t_dec), .zero_o(t_zero)
  );

  lnk_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clr_i(p_clr), .inc_i(p_inc), .last_o(p_last)
  );

  lnk_fsm #(
    .TW(TW), .LINK_TMO(LINK_TMO), .POLL_GAP(POLL_GAP), .OVRD_HOLD(OVRD_HOLD)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .max_gen_i(max_gen_i),
    .link_up_i(phy_dbg_i[LINK_UP_BIT]), .spd_busy_i(wsc_i[SPD_BUSY_BIT]),
    .gen_fld_i(lcsr_i[GEN_LSB +: 4]), .t_zero_i(t_zero), .p_last_i(p_last),
    .t_load_o(t_load), .t_val_o(t_val), .t_dec_o(t_dec),
    .p_clr_o(p_clr), .p_inc_o(p_inc), .cap_o(speed_cap_o),
    .train_o(train_en_o), .req_o(spd_chg_req_o), .ovrd_o(ovrd),
    .done_o(done_o), .fail_o(fail_o), .gen_o(gen_o)
  );

  assign rx_ovrd_o = ovrd ? OVRD_MASK : '0;
endmodule

// File: rtl/lnk_bringup_chk.sv
module lnk_bringup_chk (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [3:0]  speed_cap_o,
  input logic        train_en_o,
  input logic        spd_chg_req_o,
  input logic [15:0] rx_ovrd_o,
  input logic        done_o,
  input logic        fail_o,
  input logic [3:0]  gen_o
);
  p_cap_at_train_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(train_en_o) |-> speed_cap_o == 4'd1);

  p_cap_range_r4: assert property (@(posedge clk) disable iff (rst)
    (speed_cap_o == 4'd1) || (speed_cap_o == 4'd2));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    spd_chg_req_o |=> !spd_chg_req_o);

  p_ovrd_value_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_ovrd_o != 16'h0) |-> rx_ovrd_o == 16'h0028);

  p_fail_after_ovrd_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> $past(rx_ovrd_o) == 16'h0028);

  p_fail_gen_zero_r9: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> gen_o == 4'd0);

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !start_i) |=> fail_o);
endmodule

bind lnk_bringup lnk_bringup_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .speed_cap_o(speed_cap_o),
  .train_en_o(train_en_o), .spd_chg_req_o(spd_chg_req_o),
  .rx_ovrd_o(rx_ovrd_o), .done_o(done_o), .fail_o(fail_o), .gen_o(gen_o)
);

// File: tb/lnk_bringup_tb.sv
`timescale 1ns/1ps
module lnk_bringup_tb;
  localparam int TMO   = 300;
  localparam int GAP   = 8;
  localparam int LIMIT = 200;
  localparam int HOLD  = 500;
  localparam int INF   = 1000000000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] max_gen = 4'd1;
  logic [31:0] phy_dbg = '0, wsc = '0, lcsr = '0;
  logic [3:0] cap, gen;
  logic train, req, done, fail;
  logic [15:0] rx_ovrd;

  int n_chk = 0, n_bad = 0;
  int cfg_d1 = INF, cfg_bl = INF, cfg_d2 = INF, cfg_gen = 0;
  int ph = 0, l1cnt = 0, l2cnt = 0, bcnt = 0, reqs = 0, ov_cyc = 0;
  logic link = 1'b0, busy = 1'b0, train_q = 1'b0;
  logic [15:0] ov_val = '0;
  logic [3:0] cap_at_train = '0;

  always #2.5 clk = ~clk;

  lnk_bringup #(.LINK_TMO(TMO), .POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .OVRD_HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .max_gen_i(max_gen),
    .phy_dbg_i(phy_dbg), .wsc_i(wsc), .lcsr_i(lcsr), .speed_cap_o(cap),
    .train_en_o(train), .spd_chg_req_o(req), .rx_ovrd_o(rx_ovrd),
    .done_o(done), .fail_o(fail), .gen_o(gen)
  );

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Link partner and register model, plus output monitor (runs at negedge)
  initial begin
    forever begin
      @(negedge clk);
      if (!train) begin
        l1cnt = 0;
        link = 1'b0;
      end else if (ph == 1) begin
        l1cnt++;
        if (l1cnt >= cfg_d1) link = 1'b1;
      end
      if (req) begin
        reqs++; ph = 2; link = 1'b0; busy = 1'b1; bcnt = 0; l2cnt = 0;
      end else if (ph == 2) begin
        bcnt++;
        if (bcnt >= cfg_bl) busy = 1'b0;
        l2cnt++;
        if (l2cnt >= cfg_d2) link = 1'b1;
      end
      if (rx_ovrd != 16'h0) begin
        ov_cyc++;
        ov_val = rx_ovrd;
      end
      if (train && !train_q) cap_at_train = cap;
      train_q = train;
      phy_dbg = $urandom; phy_dbg[4] = link;
      wsc     = $urandom; wsc[17] = busy;
      lcsr    = $urandom; lcsr[19:16] = 4'(cfg_gen);
    end
  end

  function automatic bit exp_fail_f(input int d1, input int bl, input int d2);
    return (d1 >= TMO) || (bl >= LIMIT * GAP) || (d2 >= bl + TMO);
  endfunction

  task automatic run_case(input int mg, input int d1, input int bl, input int d2,
                          input int g, input bit poke);
    bit ef;
    int w;
    int ecap;
    ef = exp_fail_f(d1, bl, d2);
    ecap = (d1 >= TMO) ? 1 : ((mg == 2) ? 2 : 1);
    cfg_d1 = d1; cfg_bl = bl; cfg_d2 = d2; cfg_gen = g;
    reqs = 0; ov_cyc = 0; ov_val = '0; ph = 1; busy = 1'b0;
    max_gen = 4'(mg);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!done && !fail, "R10", "start clears done/fail", {done, fail}, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (!(done || fail) && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(done != fail, "R10", "done/fail exclusive", {done, fail}, ef ? 1 : 2);
    check(fail == ef, "R3/R6/R7", "outcome fail", fail, ef);
    check(int'(gen) == (ef ? 0 : g), "R9", "reported gen", gen, ef ? 0 : g);
    check(int'(cap) == ecap, "R4", "speed cap", cap, ecap);
    check(cap_at_train == 4'd1 && train, "R2", "cap at train enable", cap_at_train, 1);
    check(reqs == ((d1 >= TMO) ? 0 : 1), "R5", "speed change pulses", reqs, (d1 >= TMO) ? 0 : 1);
    check(ov_cyc == (ef ? HOLD : 0), "R8", "override cycles", ov_cyc, ef ? HOLD : 0);
    if (ef) check(ov_val == 16'h0028, "R8", "override value", ov_val, 16'h0028);
    if (poke) check(reqs == 1 && done, "R11", "start mid-run ignored", reqs, 1);
    repeat (20) @(negedge clk);
    check(done == !ef && fail == ef, "R10", "result held", {done, fail}, ef ? 1 : 2);
    ph = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cap == 4'd1 && !train && !req && rx_ovrd == 0 && !done && !fail && gen == 0,
          "R1", "reset state", {cap, train, req, done, fail}, 16);
    // directed corners
    run_case(2, 40, 60, 90, 2, 1'b0);             // gen2 success
    run_case(1, 40, 60, 90, 1, 1'b0);             // gen2 not allowed
    run_case(3, 40, 60, 90, 3, 1'b0);             // R4: only 2 raises
    run_case(2, TMO - 2, 30, 50, 2, 1'b0);        // R3: just inside
    run_case(2, TMO + 2, 30, 50, 2, 1'b0);        // R3: just outside
    run_case(2, INF, 30, 50, 2, 1'b0);            // R3: never up
    run_case(2, 20, LIMIT * GAP - 30, LIMIT * GAP, 2, 1'b0); // R6: last polls
    run_case(2, 20, LIMIT * GAP + 30, 50, 2, 1'b0);          // R6: too long
    run_case(2, 20, 40, INF, 2, 1'b0);            // R7: second wait fails
    run_case(2, 20, 40, 40 + TMO - 40, 5, 1'b0);  // R7: late second link-up
    run_case(2, 100, 40, 60, 2, 1'b1);            // R11
    for (int i = 0; i < 24; i++) begin
      int mg, d1, bl, d2, g;
      mg = $urandom_range(1, 3);
      d1 = ($urandom % 5 == 0) ? INF : $urandom_range(1, TMO - 20);
      bl = ($urandom % 6 == 0) ? INF : $urandom_range(1, LIMIT * GAP - 100);
      d2 = ($urandom % 6 == 0) ? INF : $urandom_range(1, ((bl == INF) ? 100 : bl) + TMO - 40);
      g  = $urandom_range(1, 15);
      run_case(mg, d1, bl, d2, g, 1'b0);
    end
    finish_up();
  end
endmodule